// File: doc/BRIEF.md
# Auto-reload multichannel PWM timer

This block produces four pulse-width-modulated outputs that share one period. An 8-bit up-counter runs from a power-of-two prescaler. When the counter passes its top value it does not go back to zero: it restarts from a programmable reload value. The PWM period is therefore set by how far below the top of the count range the reload value sits.

Each channel has a duty register. This is copied into a hidden compare register only at the counter wrap, so software can change a duty value at any time without creating a short or stretched pulse. On each wrap an enabled pin moves to its active level. It returns to its idle level when the counter steps onto that channel's compare value.

Every wrap sets a sticky flag, which can drive an interrupt. A small register port gives access to all settings and to the running counter. Software typically uses the wrap interrupt as a time base and rewrites the duty values from it, for example to step through samples of a waveform that an external filter then smooths.

Top module: `pwm_reload_timer`

## Requirements
- R1: On each prescaler tick the counter adds one. On a tick at count 255 it loads the reload value instead; this is a wrap. The wrap leaves the prescaler's position unchanged.
- R2: The control register (address 0) holds the tap field in bits [2:0]. A tap of n gives one counter tick every 2^n counted source cycles. After reset the tap is 0, which gives one tick per source cycle.
- R3: While the run bit (address 0, bit 3) is 0, the prescaler and the counter keep their values.
- R4: When the source bit (address 0, bit 4) is 1, the prescaler counts only in cycles where ext_tick_i is high. When it is 0, it counts every clock cycle.
- R5: The duty value of channel k sits at address 4+k. It reaches that channel's compare register only at a wrap. A duty write made mid-period has no effect on the pin until the next wrap.
- R6: The output control register (address 3) holds the enable bits in bits [3:0] and the polarity bits in bits [7:4]. A polarity bit of 1 makes the active level high. At a wrap an enabled pin goes to its active level. It returns to the idle level on the increment that brings the counter to its compare value.
- R7: If a channel's compare value is less than or equal to the reload value, and the counter is not written below the reload value, the pin stays at its active level for the whole period.
- R8: The reload value is at address 1. Once the first wrap has happened, the period is 256 minus the reload value, in counter ticks.
- R9: Every wrap sets the flag (address 0, bit 7). A write to address 0 with bit 7 at 0 clears the flag. irq_o is high while both the flag and the interrupt enable (address 0, bit 6) are 1.
- R10: The counter can be read and written at address 2 while it runs, and a write takes priority over counting. Writing address 0 with bit 5 at 1 loads the reload value into the counter at once. This load is not a wrap. Bit 5 always reads back as 0.
- R11: A channel whose enable bit is 0 drives the inverse of its polarity bit. After the enable bit is set again, the pin stays idle until the next wrap.
- R12: After reset every register and the counter read 0, every pin is high, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | External count enable, used as the prescaler source when selected |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i, combinational |
| pwm_o | output | 4 | PWM outputs, one bit per channel |
| irq_o | output | 1 | Wrap interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, a 7-bit prescaler and four channels. This lets it use short periods by setting large reload values (200, 230, 240), so many wraps fit in a short run, and it still covers the full 256-tick first period after reset. The four channels have mixed polarities and compare values placed above, exactly at the edge of, and below the reload value, so the no-match case runs alongside normal pulses. The taps tested are 0, 3 and 7. A pseudo-random external enable pattern exercises the gated-source path.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  // register addresses
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_RELOAD = 1;
  localparam int unsigned REG_COUNT  = 2;
  localparam int unsigned REG_OUTCTL = 3;
  localparam int unsigned REG_DUTY0  = 4;

  // control register bit positions
  localparam int unsigned CTRL_TAP_LSB = 0;
  localparam int unsigned CTRL_RUN     = 3;
  localparam int unsigned CTRL_EXT     = 4;
  localparam int unsigned CTRL_FORCE   = 5;
  localparam int unsigned CTRL_IE      = 6;
  localparam int unsigned CTRL_FLAG    = 7;

  localparam int unsigned TAP_W = 3;

  typedef struct packed {
    logic             irq_en;
    logic             ext_sel;
    logic             run;
    logic [TAP_W-1:0] tap;
  } ctrl_t;

  // low-bit mask that must be all ones in the prescaler for a tap to fire
  function automatic int unsigned tap_span(input int unsigned tap);
    return (32'd1 << tap) - 32'd1;
  endfunction

  // value the counter steps to on a plain increment
  function automatic int unsigned bump(input int unsigned value, input int unsigned width);
    return (value + 32'd1) & ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler
  import pwm_timer_pkg::*;
#(
  parameter int unsigned PRE_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ext_sel_i,
  input  logic             ext_tick_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] span;
  logic             src_tick;
  logic             adv;

  assign span     = PRE_W'(tap_span(32'(tap_i)));
  assign src_tick = ext_sel_i ? ext_tick_i : 1'b1;
  assign adv      = run_i & src_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pre_q <= '0;
    else if (adv) pre_q <= pre_q + 1'b1;
  end

  assign tick_o = adv & ((pre_q & span) == span);

  // R4: a gated-off external source freezes the divider
  assert_ext_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && !ext_tick_i) |=> $stable(pre_q));

  // R3: a stopped timer never produces a tick and holds its divider
  assert_stop_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(pre_q));
endmodule

// File: rtl/pwm_reload_counter.sv
`timescale 1ns/1ps
module pwm_reload_counter
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             step_o,
  output logic [CNT_W-1:0] step_val_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count_q;
  logic             override;
  logic             at_top;

  assign override   = load_i | force_i;
  assign at_top     = (count_q == TOP);
  assign wrap_o     = tick_i & at_top & ~override;
  assign step_o     = tick_i & ~at_top & ~override;
  assign step_val_o = CNT_W'(bump(32'(count_q), CNT_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (load_i)  count_q <= load_val_i;
    else if (force_i) count_q <= reload_i;
    else if (wrap_o)  count_q <= reload_i;
    else if (step_o)  count_q <= step_val_o;
  end

  assign count_o = count_q;

  // R1: a wrap restarts the count from the reload value
  assert_wrap_reload_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> count_q == $past(reload_i));

  // R10: a software write lands in the counter on the next edge
  assert_sw_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_q == $past(load_val_i));

  // R10: forced reload copies the reload value without a wrap
  assert_force_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_i && !load_i) |=> count_q == $past(reload_i));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] step_val_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             enable_i,
  input  logic             polarity_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_q;
  logic             act_q;
  logic             match;

  assign match = step_i & (step_val_i == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (wrap_i) cmp_q <= duty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q <= 1'b0;
    else if (!enable_i) act_q <= 1'b0;
    else if (wrap_i)    act_q <= 1'b1;
    else if (match)     act_q <= 1'b0;
  end

  assign pwm_o = (enable_i & act_q) ? polarity_i : ~polarity_i;

  // R5: the shadow compare takes the duty value present at the wrap
  assert_shadow_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> cmp_q == $past(duty_i));

  // R6: reaching the compare value returns the pin to idle
  assert_match_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && match) |=> pwm_o == $past(~polarity_i));

  // R7: a compare value at or below the reload value is never reached
  assert_low_cmp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && act_q && cmp_q <= reload_i && count_i >= reload_i) |=> act_q);
endmodule

// File: rtl/pwm_reload_timer.sv
`timescale 1ns/1ps
module pwm_reload_timer
  import pwm_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned PRE_W  = 7,
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NCH-1:0]    pwm_o,
  output logic              irq_o
);
  // polarity bits sit in the upper half of the output control register
  localparam int unsigned POL_LSB = CNT_W / 2;

  ctrl_t                      ctrl_q;
  logic [CNT_W-1:0]           reload_q;
  logic [NCH-1:0]             oe_q;
  logic [NCH-1:0]             pol_q;
  logic [NCH-1:0][CNT_W-1:0]  duty_q;
  logic                       flag_q;

  logic                       wr_ctrl, wr_reload, wr_count, wr_outctl;
  logic                       force_load;
  logic                       tick;
  logic                       wrap, step;
  logic [CNT_W-1:0]           count, step_val;

  assign wr_ctrl    = wr_en_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_reload  = wr_en_i && (addr_i == ADDR_W'(REG_RELOAD));
  assign wr_count   = wr_en_i && (addr_i == ADDR_W'(REG_COUNT));
  assign wr_outctl  = wr_en_i && (addr_i == ADDR_W'(REG_OUTCTL));
  assign force_load = wr_ctrl && wdata_i[CTRL_FORCE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.irq_en  <= wdata_i[CTRL_IE];
      ctrl_q.ext_sel <= wdata_i[CTRL_EXT];
      ctrl_q.run     <= wdata_i[CTRL_RUN];
      ctrl_q.tap     <= wdata_i[CTRL_TAP_LSB +: TAP_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        reload_q <= '0;
    else if (wr_reload) reload_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= '0;
      pol_q <= '0;
    end else if (wr_outctl) begin
      oe_q  <= wdata_i[NCH-1:0];
      pol_q <= wdata_i[POL_LSB +: NCH];
    end
  end

  // wrap sets the flag; a control write with the flag bit at 0 clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               flag_q <= 1'b0;
    else if (wrap)                             flag_q <= 1'b1;
    else if (wr_ctrl && !wdata_i[CTRL_FLAG])   flag_q <= 1'b0;
  end

  assign irq_o = flag_q & ctrl_q.irq_en;

  pwm_prescaler #(.PRE_W(PRE_W)) u_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl_q.run),
    .ext_sel_i  (ctrl_q.ext_sel),
    .ext_tick_i (ext_tick_i),
    .tap_i      (ctrl_q.tap),
    .tick_o     (tick)
  );

  pwm_reload_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (wr_count),
    .load_val_i (wdata_i),
    .force_i    (force_load),
    .reload_i   (reload_q),
    .count_o    (count),
    .wrap_o     (wrap),
    .step_o     (step),
    .step_val_o (step_val)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic wr_duty;
    assign wr_duty = wr_en_i && (addr_i == ADDR_W'(REG_DUTY0 + k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      duty_q[k] <= '0;
      else if (wr_duty) duty_q[k] <= wdata_i;
    end

    pwm_channel #(.CNT_W(CNT_W)) u_channel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wrap_i     (wrap),
      .step_i     (step),
      .step_val_i (step_val),
      .count_i    (count),
      .reload_i   (reload_q),
      .duty_i     (duty_q[k]),
      .enable_i   (oe_q[k]),
      .polarity_i (pol_q[k]),
      .pwm_o      (pwm_o[k])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(REG_CTRL)) begin
      rdata_o[CTRL_FLAG]              = flag_q;
      rdata_o[CTRL_IE]                = ctrl_q.irq_en;
      rdata_o[CTRL_EXT]               = ctrl_q.ext_sel;
      rdata_o[CTRL_RUN]               = ctrl_q.run;
      rdata_o[CTRL_TAP_LSB +: TAP_W]  = ctrl_q.tap;
    end else if (addr_i == ADDR_W'(REG_RELOAD)) begin
      rdata_o = reload_q;
    end else if (addr_i == ADDR_W'(REG_COUNT)) begin
      rdata_o = count;
    end else if (addr_i == ADDR_W'(REG_OUTCTL)) begin
      rdata_o[NCH-1:0]         = oe_q;
      rdata_o[POL_LSB +: NCH]  = pol_q;
    end
    for (int k = 0; k < NCH; k++) begin
      if (addr_i == ADDR_W'(REG_DUTY0 + k)) rdata_o = duty_q[k];
    end
  end

  // R9: every wrap leaves the flag set
  assert_flag_on_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);

  // R3: with run low and no software access the counter holds
  assert_frozen_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_count && !force_load) |=> $stable(count));

  // R10: forced reload is not a wrap, so the compare shadows stay put
  assert_force_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_load |-> !wrap);
endmodule

// File: tb/tb_pwm_reload_timer.sv
`timescale 1ns/1ps
module tb_pwm_reload_timer;
  localparam int CNT_W  = 8;
  localparam int PRE_W  = 7;
  localparam int NCH    = 4;
  localparam int ADDR_W = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ext_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  wdata = '0;
  logic [CNT_W-1:0]  rdata;
  logic [NCH-1:0]    pwm;
  logic              irq;

  always #10 clk = ~clk;

  pwm_reload_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCH(NCH), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ext_tick_i(ext_tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string phase  = "R12";

  // behavioural reference state
  int m_pre, m_cnt, m_reload, m_tap;
  bit m_run, m_sel, m_ie, m_flag;
  int m_duty[NCH];
  int m_cmp[NCH];
  bit m_act[NCH];
  bit m_oe[NCH];
  bit m_pol[NCH];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pins();
    int v = 0;
    for (int k = 0; k < NCH; k++) begin
      bit lvl;
      lvl = (m_oe[k] && m_act[k]) ? m_pol[k] : !m_pol[k];
      if (lvl) v = v | (1 << k);
    end
    return v;
  endfunction

  function automatic int exp_read(input int a);
    int v = 0;
    case (a)
      0: v = (int'(m_flag) << 7) | (int'(m_ie) << 6) | (int'(m_sel) << 4) | (int'(m_run) << 3) | m_tap;
      1: v = m_reload;
      2: v = m_cnt;
      3: begin
        for (int k = 0; k < NCH; k++) v = v | (int'(m_oe[k]) << k) | (int'(m_pol[k]) << (4 + k));
      end
      default: v = m_duty[a - 4];
    endcase
    return v;
  endfunction

  // reference model: one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_reload = 0; m_tap = 0;
      m_run = 0; m_sel = 0; m_ie = 0; m_flag = 0;
      for (int k = 0; k < NCH; k++) begin
        m_duty[k] = 0; m_cmp[k] = 0; m_act[k] = 0; m_oe[k] = 0; m_pol[k] = 0;
      end
    end else begin
      bit src, adv, tick, cw, fr, wrapped, stepped, ctrl_w;
      int period;
      period  = 1 << m_tap;
      src     = m_sel ? ext_tick : 1'b1;
      adv     = m_run && src;
      tick    = adv && ((m_pre % period) == period - 1);
      ctrl_w  = wr_en && addr == 0;
      cw      = wr_en && addr == 2;
      fr      = ctrl_w && wdata[5];
      wrapped = tick && m_cnt == 255 && !cw && !fr;
      stepped = tick && m_cnt != 255 && !cw && !fr;
      for (int k = 0; k < NCH; k++) begin
        if (!m_oe[k]) m_act[k] = 0;
        else if (wrapped) m_act[k] = 1;
        else if (stepped && (m_cnt + 1) == m_cmp[k]) m_act[k] = 0;
        if (wrapped) m_cmp[k] = m_duty[k];
      end
      if (cw) m_cnt = wdata;
      else if (fr || wrapped) m_cnt = m_reload;
      else if (stepped) m_cnt = m_cnt + 1;
      if (adv) m_pre = (m_pre + 1) % (1 << PRE_W);
      if (wrapped) m_flag = 1;
      else if (ctrl_w && !wdata[7]) m_flag = 0;
      if (ctrl_w) begin
        m_tap = wdata[2:0]; m_run = wdata[3]; m_sel = wdata[4]; m_ie = wdata[6];
      end
      if (wr_en && addr == 1) m_reload = wdata;
      if (wr_en && addr == 3) begin
        for (int k = 0; k < NCH; k++) begin
          m_oe[k] = wdata[k]; m_pol[k] = wdata[4 + k];
        end
      end
      if (wr_en && addr >= 4) m_duty[addr - 4] = wdata;
    end
  end

  // compare outputs on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " pins"}, int'(pwm), exp_pins());
      check({phase, " irq"}, int'(irq), int'(m_flag && m_ie));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int a);
    addr = ADDR_W'(a);
    #1;
    check(tag, int'(rdata), exp_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int held;
    int lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset values
    phase = "R12";
    for (int a = 0; a < 8; a++) rd("R12 read", a);
    check("R12 pins idle high", int'(pwm), 15);
    check("R12 irq low", int'(irq), 0);

    // R6 / R8 / R1: pulses with mixed polarity; ch3 compare below reload (R7)
    phase = "R6";
    wr(1, 200); wr(4, 230); wr(5, 201); wr(6, 255); wr(7, 100);
    wr(3, 8'h5F);
    wr(0, 8'h48);
    idle(280);
    phase = "R8";
    rd("R8 reload read", 1);
    idle(120);
    rd("R1 count read", 2);

    // R7: ch3 (active low) never reaches its compare value
    phase = "R7";
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check("R7 ch3 held active", int'(pwm[3]), 0);
    end

    // R9: flag and interrupt, cleared by a control write
    phase = "R9";
    rd("R9 flag set", 0);
    check("R9 irq high", int'(irq), 1);
    wr(0, 8'h48);
    check("R9 irq after clear", int'(irq), int'(m_flag && m_ie));
    idle(60);

    // R5: mid-period duty change waits for the next wrap
    phase = "R5";
    idle(20);
    wr(4, 210);
    wr(5, 250);
    idle(150);

    // R2: taps 3 and 7
    phase = "R2";
    wr(1, 240);
    wr(0, 8'h4B);
    idle(400);
    rd("R2 tap read", 0);
    wr(0, 8'h4F);
    idle(300);
    rd("R2 slow count", 2);

    // R3: stopped timer holds its count
    phase = "R3";
    wr(0, 8'h40);
    addr = ADDR_W'(2);
    #1;
    held = int'(rdata);
    idle(30);
    rd("R3 count vs model", 2);
    check("R3 count held", int'(rdata), held);

    // R4: external gated source
    phase = "R4";
    wr(1, 230);
    wr(0, 8'h58);
    lfsr = 16'hACE1;
    for (int i = 0; i < 260; i++) begin
      lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
      ext_tick = (i >= 200 && i < 230) ? 1'b0 : lfsr[0];
      @(negedge clk);
    end
    ext_tick = 1'b0;
    rd("R4 count", 2);

    // R10: software counter write and forced reload
    phase = "R10";
    wr(0, 8'h48);
    wr(2, 250);
    rd("R10 count write", 2);
    check("R10 written value", int'(rdata), 250);
    idle(3);
    wr(0, 8'h68);
    rd("R10 forced reload", 2);
    check("R10 force loads reload", int'(rdata), 230);
    rd("R10 ctrl read", 0);
    check("R10 force bit reads 0", int'(rdata[5]), 0);
    idle(80);

    // R11: disabled channel drives idle, stays idle until next wrap
    phase = "R11";
    wr(2, 100);
    wr(3, 8'h5D);
    idle(5);
    check("R11 ch1 disabled idle", int'(pwm[1]), 1);
    wr(3, 8'h5F);
    check("R11 ch1 idle before wrap", int'(pwm[1]), 1);
    idle(200);

    finish_run();
  end
endmodule